// File: doc/BRIEF.md
# Round-Robin Arbiter with Merged Data Selection

This block chooses one of several requesting input streams and forwards its data word in the same cycle. Arbitration and data selection are one structure. Each input gets a two-bit score. The upper bit is the input's valid flag and the lower bit is a stored priority bit. A binary tree of compare nodes then looks for the largest score. Every node passes the larger score and the data word that goes with it toward the root. When two scores are equal, the node keeps the one from the lower-numbered side. The direction bits chosen along the way lead to the winner. From them the block produces three forms of the grant in parallel: one-hot, thermometer and binary index.

Bit position 0 is the rightmost input, and ties go toward it. The priority state is a mask that marks every position above the last winner. Because of this, the search for the largest score behaves like a cyclic round-robin scan. The scan starts just after the previous winner, and that winner is served last. A `lock` input freezes the priority update, so the same input keeps winning for the length of a packet as long as it keeps its request up.

The inputs are valid/ready streams. The output is a single valid/ready stream. An input sees ready only when it is granted and the output is ready. Data moves only on the output handshake. The grant vectors are plain status outputs and are valid in the same cycle as the request.

Top module: `rr_maxtree_arbmux`

## Requirements
- R1: The granted input is the one with the largest score {in_valid[i], priority[i]}. Among equal scores, the lowest index wins. As a result, the winner is the first valid input found by scanning upward from the previous winner plus one, wrapping around modulo N.
- R2: When no in_valid bit is set, out_valid, gnt_onehot, gnt_therm and in_ready are all zero.
- R3: gnt_onehot has exactly the winner's bit set whenever out_valid is 1. in_ready equals gnt_onehot when out_ready is 1 and is zero otherwise.
- R4: gnt_therm has bits 0 up to and including the winner's position set, and all higher bits clear.
- R5: gnt_idx is the binary position of the winner.
- R6: out_data equals the winner's word, in_data[idx*DATA_W +: DATA_W], in the same cycle as the request.
- R7: On a clock edge where out_valid, out_ready are 1 and lock is 0, the winner becomes the lowest priority. The next search starts at winner+1.
- R8: When lock is 1, out_ready is 0 or no input is valid, the priority state keeps its value across the edge.
- R9: After reset the priority state is empty, so the lowest-indexed valid input wins first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lock | input | 1 | 1 holds the priority state (packet hold) |
| in_valid | input | N_IN | Per-input request / valid |
| in_data | input | N_IN*DATA_W | Input words, input i at bits i*DATA_W |
| in_ready | output | N_IN | Per-input ready (granted and output ready) |
| out_valid | output | 1 | Some input is granted |
| out_ready | input | 1 | Downstream accepts out_data |
| out_data | output | DATA_W | Word of the granted input |
| gnt_onehot | output | N_IN | One-hot grant |
| gnt_therm | output | N_IN | Thermometer grant, bits 0..winner set |
| gnt_idx | output | $clog2(N_IN) | Binary index of the winner |

## Verification
The bench builds the block with N_IN=4 and DATA_W=8. With these values it can sweep every request pattern against every previous-winner state. It does so under each combination of handshake and lock, which covers every tie and every wrap-around of the cyclic order. After each pattern it sends an all-valid probe without a handshake. The winner of that probe shows whether the priority mask moved or held.

// File: rtl/rr_mt_pkg.sv
package rr_mt_pkg;

  typedef logic [1:0] sym_t;

  // Score of one input: request on top, priority below.
  function automatic sym_t mk_sym(input logic rq, input logic pr);
    return {rq, pr};
  endfunction

endpackage

// File: rtl/rr_max_node.sv
module rr_max_node
  import rr_mt_pkg::*;
#(
  parameter int N  = 8,
  parameter int DW = 8,
  parameter logic [N-1:0] RSPAN = '0
) (
  input  sym_t          l_sym,
  input  sym_t          r_sym,
  input  logic [DW-1:0] l_dat,
  input  logic [DW-1:0] r_dat,
  input  logic [N-1:0]  l_oh,
  input  logic [N-1:0]  r_oh,
  input  logic [N-1:0]  l_th,
  input  logic [N-1:0]  r_th,
  output sym_t          o_sym,
  output logic [DW-1:0] o_dat,
  output logic [N-1:0]  o_oh,
  output logic [N-1:0]  o_th,
  output logic          flag
);

  // Strict compare: on a tie the right (lower) side is kept.
  assign flag  = (l_sym > r_sym);
  assign o_sym = flag ? l_sym : r_sym;
  assign o_dat = flag ? l_dat : r_dat;
  assign o_oh  = flag ? l_oh  : r_oh;
  // A left winner sits above every position of the right subtree.
  assign o_th  = flag ? (l_th | RSPAN) : r_th;

endmodule

// File: rtl/rr_max_tree.sv
module rr_max_tree
  import rr_mt_pkg::*;
#(
  parameter int N  = 8,
  parameter int DW = 8,
  localparam int IW = $clog2(N),
  localparam int NODES = 2 * N
) (
  input  logic [N-1:0]    req,
  input  logic [N-1:0]    pri,
  input  logic [N*DW-1:0] dat,
  output logic            root_valid,
  output logic [DW-1:0]   root_dat,
  output logic [N-1:0]    root_oh,
  output logic [N-1:0]    root_th,
  output logic [IW-1:0]   root_idx
);

  // Heap numbering: node n has children 2n (right, lower) and 2n+1 (left).
  sym_t          s_v  [1:NODES-1];
  logic [DW-1:0] d_v  [1:NODES-1];
  logic [N-1:0]  oh_v [1:NODES-1];
  logic [N-1:0]  th_v [1:NODES-1];
  logic [IW-1:0] ix_v [1:NODES-1];
  logic          fl_v [1:N-1];

  // Leaf positions covered by heap node 'node'.
  function automatic logic [N-1:0] span_of(input int node);
    logic [N-1:0] m;
    m = '0;
    for (int p = 0; p < N; p++) begin
      for (int k = 0; k <= IW; k++) begin
        if (((N + p) >> k) == node) m[p] = 1'b1;
      end
    end
    return m;
  endfunction

  for (genvar p = 0; p < N; p++) begin : g_leaf
    assign s_v[N+p]  = mk_sym(req[p], pri[p]);
    assign d_v[N+p]  = dat[p*DW +: DW];
    assign oh_v[N+p] = N'(1) << p;
    assign th_v[N+p] = N'(1) << p;
    assign ix_v[N+p] = IW'(p);
  end

  for (genvar n = 1; n < N; n++) begin : g_node
    rr_max_node #(
      .N(N), .DW(DW), .RSPAN(span_of(2 * n))
    ) u_node (
      .l_sym(s_v[2*n+1]), .r_sym(s_v[2*n]),
      .l_dat(d_v[2*n+1]), .r_dat(d_v[2*n]),
      .l_oh (oh_v[2*n+1]), .r_oh (oh_v[2*n]),
      .l_th (th_v[2*n+1]), .r_th (th_v[2*n]),
      .o_sym(s_v[n]), .o_dat(d_v[n]),
      .o_oh (oh_v[n]), .o_th (th_v[n]),
      .flag (fl_v[n])
    );
    // The flags along the winning path spell out the index.
    assign ix_v[n] = fl_v[n] ? ix_v[2*n+1] : ix_v[2*n];
  end

  assign root_valid = s_v[1][1];
  assign root_dat   = d_v[1];
  assign root_oh    = oh_v[1];
  assign root_th    = th_v[1];
  assign root_idx   = ix_v[1];

endmodule

// File: rtl/rr_prio_state.sv
module rr_prio_state #(
  parameter int N = 8,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd,
  input  logic [IW-1:0] win_idx,
  output logic [N-1:0]  pri
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pri <= '0;
    end else if (upd) begin
      for (int i = 0; i < N; i++) begin
        pri[i] <= (i > int'(win_idx));
      end
    end
  end

  // R7: the winner loses its priority bit and its upper neighbour gains one.
  a_r7_winner_demoted: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> !pri[$past(win_idx)]);
  a_r7_next_promoted: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && (win_idx != IW'(N-1))) |=> pri[$past(win_idx) + IW'(1)]);
  // R9: position 0 is never marked, and the mask only ever fills upward.
  a_r9_mask_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (!pri[0]) && (((pri << 1) & ~pri) == '0));

endmodule

// File: rtl/rr_maxtree_arbmux.sv
module rr_maxtree_arbmux #(
  parameter int N_IN   = 8,
  parameter int DATA_W = 8,
  localparam int IW = $clog2(N_IN)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   lock,
  input  logic [N_IN-1:0]        in_valid,
  input  logic [N_IN*DATA_W-1:0] in_data,
  output logic [N_IN-1:0]        in_ready,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [DATA_W-1:0]      out_data,
  output logic [N_IN-1:0]        gnt_onehot,
  output logic [N_IN-1:0]        gnt_therm,
  output logic [IW-1:0]          gnt_idx
);

  logic [N_IN-1:0] pri;
  logic            t_valid;
  logic [N_IN-1:0] t_oh;
  logic [N_IN-1:0] t_th;
  logic            fire;

  initial begin
    a_cfg_pow2: assert (N_IN >= 2 && (N_IN & (N_IN - 1)) == 0);
  end

  rr_max_tree #(.N(N_IN), .DW(DATA_W)) u_tree (
    .req       (in_valid),
    .pri       (pri),
    .dat       (in_data),
    .root_valid(t_valid),
    .root_dat  (out_data),
    .root_oh   (t_oh),
    .root_th   (t_th),
    .root_idx  (gnt_idx)
  );

  assign out_valid  = t_valid;
  assign gnt_onehot = t_valid ? t_oh : '0;
  assign gnt_therm  = t_valid ? t_th : '0;
  assign in_ready   = out_ready ? gnt_onehot : '0;
  assign fire       = t_valid && out_ready && !lock;

  rr_prio_state #(.N(N_IN)) u_prio (
    .clk    (clk),
    .rst_n  (rst_n),
    .upd    (fire),
    .win_idx(gnt_idx),
    .pri    (pri)
  );

  always_comb begin
    // R2: a grant appears exactly when some input requests.
    a_r2_valid_any: assert (out_valid == (|in_valid));
    // R3: at most one input granted.
    a_r3_onehot: assert ($onehot0(gnt_onehot));
    if (out_valid) begin
      // R1: the winner is a requesting input.
      a_r1_winner_requests: assert (in_valid[gnt_idx]);
      // R5: the index path and the one-hot path agree.
      a_r5_idx_match: assert (gnt_onehot[gnt_idx]);
      // R4: the thermometer edge sits just above the one-hot bit.
      a_r4_therm_edge: assert (gnt_therm == ((gnt_onehot << 1) - N_IN'(1)));
      // R6: the data path carried the winner's word.
      a_r6_data_match: assert (out_data == in_data[gnt_idx*DATA_W +: DATA_W]);
    end
  end

  // R8: without an unlocked handshake the priority state stays put.
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && out_ready && !lock) |=> $stable(pri));

endmodule

// File: tb/rr_maxtree_arbmux_tb.sv
module rr_maxtree_arbmux_tb;

  localparam int N  = 4;
  localparam int DW = 8;
  localparam int IW = 2;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            lock;
  logic [N-1:0]    in_valid;
  logic [N*DW-1:0] in_data;
  logic [N-1:0]    in_ready;
  logic            out_valid;
  logic            out_ready;
  logic [DW-1:0]   out_data;
  logic [N-1:0]    gnt_onehot;
  logic [N-1:0]    gnt_therm;
  logic [IW-1:0]   gnt_idx;

  int n_chk  = 0;
  int n_fail = 0;
  int last_w;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rr_maxtree_arbmux #(.N_IN(N), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .lock(lock),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .gnt_onehot(gnt_onehot), .gnt_therm(gnt_therm), .gnt_idx(gnt_idx)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int pick(input int vmask, input int lw);
    for (int k = 1; k <= N; k++) begin
      int p;
      p = (lw + k) % N;
      if (vmask[p]) return p;
    end
    return -1;
  endfunction

  function automatic int dword(input int p, input int tag);
    return (p * 37 + tag * 5 + 3) % 256;
  endfunction

  // Drive at the falling edge, check 1 ns later, update the model for the next rising edge.
  task automatic step(input int v, input bit rdy, input bit lk, input int tag, input string ctx);
    int w;
    @(negedge clk);
    in_valid  = N'(v);
    out_ready = rdy;
    lock      = lk;
    for (int p = 0; p < N; p++) in_data[p*DW +: DW] = DW'(dword(p, tag));
    #1;
    w = pick(v, last_w);
    if (w < 0) begin
      chk({ctx, " R2 out_valid"}, int'(out_valid), 0);
      chk({ctx, " R2 onehot"}, int'(gnt_onehot), 0);
      chk({ctx, " R2 therm"}, int'(gnt_therm), 0);
      chk({ctx, " R2 in_ready"}, int'(in_ready), 0);
    end else begin
      chk({ctx, " R1 out_valid"}, int'(out_valid), 1);
      chk({ctx, " R3 onehot"}, int'(gnt_onehot), 1 << w);
      chk({ctx, " R3 in_ready"}, int'(in_ready), rdy ? (1 << w) : 0);
      chk({ctx, " R4 therm"}, int'(gnt_therm), (1 << (w + 1)) - 1);
      chk({ctx, " R5 idx"}, int'(gnt_idx), w);
      chk({ctx, " R6 data"}, int'(out_data), dword(w, tag));
      if (rdy && !lk) last_w = w;
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; lock = 1'b0; out_ready = 1'b0; in_valid = '0; in_data = '0;
    last_w = N - 1;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R9: empty priority after reset, so position 0 wins an all-valid probe.
    step(4'hF, 1'b0, 1'b0, 1, "R9 reset");
    step(0, 1'b1, 1'b0, 2, "R2 idle");
    step(4'hF, 1'b0, 1'b0, 3, "R8 idle hold");
    // Sweep: previous winner x request pattern x handshake/lock mode, then probe.
    for (int w0 = 0; w0 < N; w0++) begin
      for (int pat = 0; pat < (1 << N); pat++) begin
        for (int mode = 0; mode < 3; mode++) begin
          step(1 << w0, 1'b1, 1'b0, pat, "R7 set state");
          step(pat, (mode != 2), (mode == 1), pat + mode, "R1 sweep");
          step(4'hF, 1'b0, 1'b0, pat + 7, (mode == 0) ? "R7 probe" : "R8 probe");
        end
      end
    end
    // R7: continuous all-valid traffic rotates through every input in turn.
    for (int k = 0; k < 2 * N; k++) step(4'hF, 1'b1, 1'b0, k, "R7 rotate");
    // R8: lock keeps the same input granted while it requests.
    for (int k = 0; k < N; k++) step(4'hF, 1'b1, 1'b1, k, "R8 locked");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule